// File: doc/BRIEF.md
# Dual-Channel Wiper and Comparator Control Register Bank

This block holds the digital state behind two digitally controlled potentiometers and their two voltage comparators. It has four working registers, called units: the two wiper position registers and the two comparator control registers. Each unit owns four 6-bit storage registers that stand in for nonvolatile cells. An upstream serial front end decodes each command and presents it here for one clock as an opcode, a unit number, a storage index and a data byte. The bank performs the command and returns read data one clock later.

Working registers can be read, written and stepped up or down by one position. Storage registers can be read and written. Values can be copied between a unit's working register and one of its storage registers, either for one unit or for all four units at once. Any write to a storage register is a nonvolatile write. A low write-protect pin refuses these writes. An accepted one holds a busy flag for a programmed number of clocks, and every command presented during that time is dropped. Reset loads every working register from storage register 0 of its unit. Storage contents survive reset.

Each comparator control register gates its channel's raw comparator result. One bit drives the output enable, one bit freezes the output value and one bit forces the output low.

Top module: `dcp_regbank`

## Requirements
- R1: Units are numbered 0 and 1 for the wiper registers of channels 0 and 1, and 2 and 3 for the control registers of channels 0 and 1. Opcode 4'h1 reads the working register of `cmd_unit`. `rd_valid` is high and `rd_data` holds the value in the cycle after the command is accepted. `rd_valid` is low in every cycle that does not follow an accepted read.
- R2: Opcode 4'h2 writes `cmd_wdata` into the working register of `cmd_unit`. A wiper value shows on `wiper_pos` (channel c at bits [6c+5:6c]) in the next cycle. This write is volatile: it works with `wp_n` low and does not raise `busy`.
- R3: Opcode 4'h3 reads storage register `cmd_idx` of `cmd_unit` with the same timing as R1. Opcode 4'h4 writes `cmd_wdata` into that storage register as a nonvolatile write.
- R4: Opcode 4'h5 copies storage register `cmd_idx` of `cmd_unit` into its working register (volatile). Opcode 4'h6 copies the working register into storage register `cmd_idx` (nonvolatile).
- R5: Opcodes 4'h7 (storage to working) and 4'h8 (working to storage, nonvolatile) act on all four units at once with the same `cmd_idx`, whatever `cmd_unit` is.
- R6: With `wp_n` low, opcodes 4'h4, 4'h6 and 4'h8 change no storage register and do not raise `busy`.
- R7: An accepted nonvolatile write raises `busy` in the next cycle and holds it for exactly BUSY_CYCLES cycles. A command presented while `busy` is high changes no register and produces no read response.
- R8: During reset each working register takes the value of storage register 0 of its unit. Storage registers keep their contents through reset. `busy` and `rd_valid` are low after reset.
- R9: Opcode 4'h9 steps the wiper register of `cmd_unit` up by one when `cmd_wdata[0]` is 1 and down by one when it is 0. The value saturates at 63 and at 0. On units 2 and 3 the opcode changes nothing.
- R10: Opcodes 4'h0 and 4'hA to 4'hF change no register, do not raise `busy` and produce no read response.
- R11: In a control register, bit 0 drives `cmp_oe`, bit 2 forces `cmp_out` low, and bit 1 makes `cmp_out` hold the `cmp_raw` value sampled at the clock edge that set bit 1. Otherwise `cmp_out` follows `cmp_raw` in the same cycle. Bits 5:3 are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; recalls working registers |
| wp_n | input | 1 | Write protect, low refuses nonvolatile writes |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 4 | Opcode |
| cmd_unit | input | 2 | Unit number (0,1 wipers; 2,3 control registers) |
| cmd_idx | input | 2 | Storage register index |
| cmd_wdata | input | 6 | Write data; bit 0 gives the step direction |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 6 | Read data |
| busy | output | 1 | Nonvolatile write in progress |
| wiper_pos | output | 12 | Wiper positions, channel 0 in the low 6 bits |
| cmp_raw | input | 2 | Raw comparator results per channel |
| cmp_out | output | 2 | Gated comparator outputs |
| cmp_oe | output | 2 | Comparator output enables |

## Verification
A wrong working register shows on `wiper_pos`, `cmp_out` or `cmp_oe` in the cycle after the faulty update, and a reference model compares those ports every clock. A wrong storage register shows only when it is later read back or copied into a working register. The bench therefore reads back after every storage write and after the recall at a second reset. A busy timer that is off by one cycle, or a command that slips through while busy, shows on `busy` or `rd_valid` within one clock.

// File: rtl/dcp_pkg.sv
// Shared definitions for the wiper/control register bank.
// Assumes 4-bit opcodes; values outside 1..9 are undefined and ignored.
package dcp_pkg;

    typedef enum logic [3:0] {
        OP_RD_WORK = 4'h1,
        OP_WR_WORK = 4'h2,
        OP_RD_DATA = 4'h3,
        OP_WR_DATA = 4'h4,
        OP_LOAD    = 4'h5,
        OP_SAVE    = 4'h6,
        OP_GLOAD   = 4'h7,
        OP_GSAVE   = 4'h8,
        OP_STEP    = 4'h9
    } op_e;

    // Control register bit positions (neighbour logic decodes these)
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_LAT_BIT = 1;
    localparam int CTL_SD_BIT  = 2;

    // One-hot style strobes for an accepted command
    typedef struct packed {
        logic rd_work;
        logic wr_work;
        logic rd_data;
        logic wr_data;
        logic load;
        logic save;
        logic step;
        logic glob;
    } cmd_ctl_t;

    function automatic logic is_nv_op(input logic [3:0] op);
        return (op == OP_WR_DATA) || (op == OP_SAVE) || (op == OP_GSAVE);
    endfunction

    function automatic logic is_rd_op(input logic [3:0] op);
        return (op == OP_RD_WORK) || (op == OP_RD_DATA);
    endfunction

    function automatic logic is_defined_op(input logic [3:0] op);
        return (op >= OP_RD_WORK) && (op <= OP_STEP);
    endfunction

endpackage

// File: rtl/dcp_cmd_decode.sv
// Command decoder: turns a presented command into strobes.
// Drops everything while busy and refuses nonvolatile writes when
// write protect is low. Purely combinational.
module dcp_cmd_decode
    import dcp_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [3:0] cmd_op,
    input  logic       busy,
    input  logic       wp_n,
    output cmd_ctl_t   ctl,
    output logic       nv_start
);

    logic accept;
    assign accept = cmd_valid && !busy;

    // Opcode to strobe mapping
    always_comb begin
        ctl      = '0;
        nv_start = 1'b0;
        if (accept) begin
            case (cmd_op)
                OP_RD_WORK: ctl.rd_work = 1'b1;
                OP_WR_WORK: ctl.wr_work = 1'b1;
                OP_RD_DATA: ctl.rd_data = 1'b1;
                OP_WR_DATA: begin
                    ctl.wr_data = wp_n;
                    nv_start    = wp_n;
                end
                OP_LOAD:    ctl.load = 1'b1;
                OP_SAVE: begin
                    ctl.save = wp_n;
                    nv_start = wp_n;
                end
                OP_GLOAD: begin
                    ctl.load = 1'b1;
                    ctl.glob = 1'b1;
                end
                OP_GSAVE: begin
                    ctl.save = wp_n;
                    ctl.glob = wp_n;
                    nv_start = wp_n;
                end
                OP_STEP:    ctl.step = 1'b1;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/dcp_nv_timer.sv
// Nonvolatile write timer: busy for BUSY_CYCLES clocks after a start.
// Assumes start only arrives while not busy (decoder guarantees it).
module dcp_nv_timer #(
    parameter int BUSY_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(BUSY_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/dcp_unit_store.sv
// One unit: a working register plus NREG storage registers.
// Storage registers have no reset, since they model nonvolatile cells.
// Reset recalls storage register 0 into the working register.
// Stepping is only built in when IS_WIPER is set.
module dcp_unit_store
    import dcp_pkg::*;
#(
    parameter int DW       = 6,
    parameter int NREG     = 4,
    parameter bit IS_WIPER = 1'b1,
    localparam int IW      = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  cmd_ctl_t      ctl,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] work,
    output logic [DW-1:0] dr_sel,
    output logic [DW-1:0] dr_r0
);

    localparam logic [DW-1:0] TOP_VAL = {DW{1'b1}};

    logic [DW-1:0] dr_q [NREG];
    logic [DW-1:0] work_q;
    logic          hit;

    assign hit = sel || ctl.glob;

    // Storage write: direct data or copy of the working register
    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (hit && ctl.wr_data)
                dr_q[idx] <= wdata;
            else if (hit && ctl.save)
                dr_q[idx] <= work_q;
        end
    end

    // Working register: recall, write, load or step
    always_ff @(posedge clk) begin
        if (!rst_n)
            work_q <= dr_q[0];
        else if (hit && ctl.wr_work)
            work_q <= wdata;
        else if (hit && ctl.load)
            work_q <= dr_q[idx];
        else if (hit && ctl.step && IS_WIPER) begin
            if (wdata[0])
                work_q <= (work_q == TOP_VAL) ? work_q : work_q + DW'(1);
            else
                work_q <= (work_q == '0) ? work_q : work_q - DW'(1);
        end
    end

    assign work   = work_q;
    assign dr_sel = dr_q[idx];
    assign dr_r0  = dr_q[0];

endmodule

// File: rtl/dcp_cmp_gate.sv
// Comparator output gating for one channel from its control register.
// The held flop tracks the raw input while the freeze bit is clear.
// The output path from cmp_raw is combinational.
module dcp_cmp_gate
    import dcp_pkg::*;
#(
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ctl_reg,
    input  logic          raw,
    output logic          out,
    output logic          oe
);

    logic held_q;

    // Capture raw while not frozen
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= 1'b0;
        else if (!ctl_reg[CTL_LAT_BIT])
            held_q <= raw;
    end

    assign out = ctl_reg[CTL_SD_BIT]  ? 1'b0 :
                 ctl_reg[CTL_LAT_BIT] ? held_q : raw;
    assign oe  = ctl_reg[CTL_EN_BIT];

endmodule

// File: rtl/dcp_regbank.sv
// Top of the register bank: NCH wiper units and NCH control units,
// each with NREG storage registers, a shared command decoder, a
// nonvolatile busy timer and per-channel comparator gating.
// Assumes commands arrive already decoded, one per cycle.
module dcp_regbank
    import dcp_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int DW          = 6,
    parameter int NREG        = 4,
    parameter int BUSY_CYCLES = 50000,
    localparam int NUNIT      = 2 * NCH,
    localparam int UW         = $clog2(NUNIT),
    localparam int IW         = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [UW-1:0]     cmd_unit,
    input  logic [IW-1:0]     cmd_idx,
    input  logic [DW-1:0]     cmd_wdata,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              busy,
    output logic [NCH*DW-1:0] wiper_pos,
    input  logic [NCH-1:0]    cmp_raw,
    output logic [NCH-1:0]    cmp_out,
    output logic [NCH-1:0]    cmp_oe
);

    cmd_ctl_t            ctl;
    logic                nv_start;
    logic [DW-1:0]       work_v  [NUNIT];
    logic [DW-1:0]       drsel_v [NUNIT];
    logic [DW-1:0]       r0_v    [NUNIT];
    logic [NUNIT*DW-1:0] work_flat;
    logic [NUNIT*DW-1:0] r0_flat;

    dcp_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .busy      (busy),
        .wp_n      (wp_n),
        .ctl       (ctl),
        .nv_start  (nv_start)
    );

    dcp_nv_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_start),
        .busy  (busy)
    );

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        dcp_unit_store #(
            .DW       (DW),
            .NREG     (NREG),
            .IS_WIPER (u < NCH)
        ) u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (cmd_unit == UW'(u)),
            .ctl    (ctl),
            .idx    (cmd_idx),
            .wdata  (cmd_wdata),
            .work   (work_v[u]),
            .dr_sel (drsel_v[u]),
            .dr_r0  (r0_v[u])
        );
        assign work_flat[u*DW +: DW] = work_v[u];
        assign r0_flat[u*DW +: DW]   = r0_v[u];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign wiper_pos[c*DW +: DW] = work_v[c];

        dcp_cmp_gate #(.DW(DW)) u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_reg (work_v[NCH + c]),
            .raw     (cmp_raw[c]),
            .out     (cmp_out[c]),
            .oe      (cmp_oe[c])
        );
    end

    // Read response register: one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= ctl.rd_work || ctl.rd_data;
            if (ctl.rd_work)
                rd_data <= work_v[cmd_unit];
            else if (ctl.rd_data)
                rd_data <= drsel_v[cmd_unit];
        end
    end

endmodule

// File: rtl/dcp_regbank_chk.sv
// Property checker for dcp_regbank, attached by bind below.
// Assumes the top's internal work_flat and r0_flat concatenations.
module dcp_regbank_chk
    import dcp_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int DW          = 6,
    parameter int BUSY_CYCLES = 50000,
    localparam int NUNIT      = 2 * NCH
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n,
    input logic              cmd_valid,
    input logic [3:0]        cmd_op,
    input logic              busy,
    input logic              rd_valid,
    input logic [NCH-1:0]    cmp_out,
    input logic [NUNIT*DW-1:0] work_flat,
    input logic [NUNIT*DW-1:0] r0_flat
);

    int                  run_q;
    logic                was_rst_q;
    logic [NUNIT*DW-1:0] r0_q;

    // Length of the current busy run
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 0;
        else
            run_q <= busy ? run_q + 1 : 0;
    end

    // Remember reset and storage register 0 of the previous cycle
    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
        r0_q      <= r0_flat;
    end

    assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rst_n)) |-> (run_q == BUSY_CYCLES));

    assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> ($stable(work_flat) && !rd_valid));

    assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !wp_n && is_nv_op(cmd_op)) |=> !busy);

    assert_rd_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && !busy && is_rd_op(cmd_op)));

    assert_undef_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !is_defined_op(cmd_op))
            |=> ($stable(work_flat) && !rd_valid && !busy));

    for (genvar c = 0; c < NCH; c++) begin : g_sd
        assert_shutdown_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
            work_flat[(NCH + c)*DW + CTL_SD_BIT] |-> !cmp_out[c]);
    end

    // Recall check one cycle after a reset edge
    always @(posedge clk) begin
        if (was_rst_q && !$isunknown(r0_q))
            assert_recall_R8: assert (work_flat == r0_q)
                else $error("recall mismatch");
    end

endmodule

bind dcp_regbank dcp_regbank_chk #(
    .NCH         (NCH),
    .DW          (DW),
    .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_n      (wp_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .cmp_out   (cmp_out),
    .work_flat (work_flat),
    .r0_flat   (r0_flat)
);

// File: tb/tb_dcp_regbank.sv
module tb_dcp_regbank;

    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 2;
    localparam int DW    = 6;
    localparam int NREG  = 4;
    localparam int BUSY  = 20;
    localparam int NUNIT = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wp_n = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [3:0]        cmd_op = '0;
    logic [1:0]        cmd_unit = '0;
    logic [1:0]        cmd_idx = '0;
    logic [DW-1:0]     cmd_wdata = '0;
    logic              rd_valid;
    logic [DW-1:0]     rd_data;
    logic              busy;
    logic [NCH*DW-1:0] wiper_pos;
    logic [NCH-1:0]    cmp_raw = '0;
    logic [NCH-1:0]    cmp_out;
    logic [NCH-1:0]    cmp_oe;

    dcp_regbank #(.NCH(NCH), .DW(DW), .NREG(NREG), .BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_unit(cmd_unit), .cmd_idx(cmd_idx),
        .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .wiper_pos(wiper_pos), .cmp_raw(cmp_raw),
        .cmp_out(cmp_out), .cmp_oe(cmp_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_work [NUNIT];
    bit m_wk   [NUNIT];
    int m_dr   [NUNIT][NREG];
    bit m_drk  [NUNIT][NREG];
    int m_held [NCH];
    bit m_hk   [NCH];
    int m_busy = 0;
    bit m_rdv = 0;
    int m_rdd = 0;
    bit m_rdk = 0;

    always @(posedge clk) begin : model
        int un;
        int ix;
        int wd;
        un = int'(cmd_unit);
        ix = int'(cmd_idx);
        wd = int'(cmd_wdata);
        if (!rst_n) begin
            for (int u = 0; u < NUNIT; u++) begin
                m_work[u] = m_dr[u][0];
                m_wk[u]   = m_drk[u][0];
            end
            for (int c = 0; c < NCH; c++) begin
                m_held[c] = 0;
                m_hk[c]   = 1'b1;
            end
            m_busy = 0;
            m_rdv  = 1'b0;
            m_rdd  = 0;
            m_rdk  = 1'b1;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (!m_wk[NCH+c]) m_hk[c] = 1'b0;
                else if (((m_work[NCH+c] >> 1) & 1) == 0) begin
                    m_held[c] = int'(cmp_raw[c]);
                    m_hk[c]   = 1'b1;
                end
            end
            m_rdv = 1'b0;
            if (m_busy > 0) m_busy--;
            else if (cmd_valid) begin
                case (cmd_op)
                    4'h1: begin m_rdv = 1; m_rdd = m_work[un]; m_rdk = m_wk[un]; end
                    4'h2: begin m_work[un] = wd; m_wk[un] = 1; end
                    4'h3: begin m_rdv = 1; m_rdd = m_dr[un][ix]; m_rdk = m_drk[un][ix]; end
                    4'h4: if (wp_n) begin
                        m_dr[un][ix] = wd; m_drk[un][ix] = 1; m_busy = BUSY;
                    end
                    4'h5: begin m_work[un] = m_dr[un][ix]; m_wk[un] = m_drk[un][ix]; end
                    4'h6: if (wp_n) begin
                        m_dr[un][ix] = m_work[un]; m_drk[un][ix] = m_wk[un]; m_busy = BUSY;
                    end
                    4'h7: for (int u = 0; u < NUNIT; u++) begin
                        m_work[u] = m_dr[u][ix]; m_wk[u] = m_drk[u][ix];
                    end
                    4'h8: if (wp_n) begin
                        for (int u = 0; u < NUNIT; u++) begin
                            m_dr[u][ix] = m_work[u]; m_drk[u][ix] = m_wk[u];
                        end
                        m_busy = BUSY;
                    end
                    4'h9: if (un < NCH) begin
                        if (wd % 2 == 1) m_work[un] = (m_work[un] == 63) ? 63 : m_work[un] + 1;
                        else             m_work[un] = (m_work[un] == 0) ? 0 : m_work[un] - 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk("R7 busy per-cycle", int'(busy), (m_busy != 0) ? 1 : 0);
            chk("R1 rd_valid per-cycle", int'(rd_valid), int'(m_rdv));
            if (m_rdv && m_rdk) chk("R1 rd_data per-cycle", int'(rd_data), m_rdd);
            for (int c = 0; c < NCH; c++) begin
                if (m_wk[c]) chk("R2 wiper_pos per-cycle", int'(wiper_pos[c*DW +: DW]), m_work[c]);
                if (m_wk[NCH+c]) begin
                    int a;
                    a = m_work[NCH+c];
                    chk("R11 cmp_oe per-cycle", int'(cmp_oe[c]), a & 1);
                    if ((a >> 2) & 1) chk("R11 cmp_out per-cycle", int'(cmp_out[c]), 0);
                    else if ((a >> 1) & 1) begin
                        if (m_hk[c]) chk("R11 cmp_out per-cycle", int'(cmp_out[c]), m_held[c]);
                    end else chk("R11 cmp_out per-cycle", int'(cmp_out[c]), int'(cmp_raw[c]));
                end
            end
        end
    end

    task automatic cmd(input logic [3:0] op, input int unit, input int idx, input int data);
        @(posedge clk); #1;
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_unit  = unit[1:0];
        cmd_idx   = idx[1:0];
        cmd_wdata = data[DW-1:0];
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        cmd_op    = '0;
    endtask

    task automatic rd_chk(input logic [3:0] op, input int unit, input int idx,
                          input string tag, input int exp);
        cmd(op, unit, idx, 0);
        chk({tag, " rd_valid"}, int'(rd_valid), 1);
        chk({tag, " rd_data"}, int'(rd_data), exp);
    endtask

    task automatic wait_idle();
        repeat (BUSY + 2) @(posedge clk);
        #1;
    endtask

    function automatic int init_val(input int u, input int i);
        return (u * 16 + i * 5 + 3) % 64;
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        int n;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_en = 1'b1;
        #1;
        chk("R8 busy after reset", int'(busy), 0);
        chk("R8 rd_valid after reset", int'(rd_valid), 0);

        // Program all storage registers (R3)
        for (int u = 0; u < NUNIT; u++)
            for (int i = 0; i < NREG; i++) begin
                cmd(4'h4, u, i, init_val(u, i));
                wait_idle();
            end
        rd_chk(4'h3, 2, 3, "R3 storage read u2 i3", 50);
        rd_chk(4'h3, 3, 3, "R3 storage read u3 i3", 2);

        // Working writes (R2)
        cmd(4'h2, 0, 0, 10);
        cmd(4'h2, 1, 0, 20);
        cmd(4'h2, 2, 0, 1);
        cmd(4'h2, 3, 0, 0);
        chk("R2 wiper ch0 after write", int'(wiper_pos[5:0]), 10);
        rd_chk(4'h1, 1, 0, "R1 read wiper u1", 20);

        // Stepping (R9)
        repeat (3) cmd(4'h9, 0, 0, 1);
        chk("R9 step up x3", int'(wiper_pos[5:0]), 13);
        cmd(4'h2, 1, 0, 62);
        chk("R2 wiper ch1 after write", int'(wiper_pos[11:6]), 62);
        repeat (2) cmd(4'h9, 1, 0, 1);
        chk("R9 saturate at 63", int'(wiper_pos[11:6]), 63);
        cmd(4'h2, 1, 0, 1);
        repeat (2) cmd(4'h9, 1, 0, 0);
        chk("R9 saturate at 0", int'(wiper_pos[11:6]), 0);
        cmd(4'h9, 2, 0, 1);
        rd_chk(4'h1, 2, 0, "R9 step ignored on control unit", 1);

        // Single transfers (R4) and busy length (R7)
        cmd(4'h5, 0, 1, 0);
        chk("R4 load storage to wiper", int'(wiper_pos[5:0]), 8);
        cmd(4'h6, 1, 3, 0);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(posedge clk); #1;
        end
        chk("R7 busy length", n, BUSY);
        rd_chk(4'h3, 1, 3, "R4 save wiper to storage", 0);

        // Global transfers (R5)
        cmd(4'h2, 0, 0, 5);
        cmd(4'h2, 1, 0, 6);
        cmd(4'h2, 2, 0, 7);
        cmd(4'h2, 3, 0, 9);
        cmd(4'h8, 1, 2, 0);
        wait_idle();
        rd_chk(4'h3, 0, 2, "R5 global save u0", 5);
        rd_chk(4'h3, 3, 2, "R5 global save u3", 9);
        cmd(4'h7, 2, 0, 0);
        chk("R5 global load ch0", int'(wiper_pos[5:0]), 3);
        chk("R5 global load ch1", int'(wiper_pos[11:6]), 19);
        rd_chk(4'h1, 2, 0, "R5 global load u2", 35);

        // Write protect (R6)
        wp_n = 1'b0;
        cmd(4'h4, 0, 0, 55);
        chk("R6 no busy under protect", int'(busy), 0);
        rd_chk(4'h3, 0, 0, "R6 storage kept after write", 3);
        cmd(4'h2, 0, 0, 40);
        chk("R2 volatile write under protect", int'(wiper_pos[5:0]), 40);
        cmd(4'h8, 0, 0, 0);
        chk("R6 no busy after global save", int'(busy), 0);
        rd_chk(4'h3, 0, 0, "R6 storage kept after global save", 3);
        cmd(4'h6, 1, 0, 0);
        rd_chk(4'h3, 1, 0, "R6 storage kept after save", 19);
        wp_n = 1'b1;

        // Commands dropped while busy (R7)
        cmd(4'h4, 0, 3, 7);
        cmd(4'h2, 0, 0, 44);
        chk("R7 write dropped while busy", int'(wiper_pos[5:0]), 40);
        cmd(4'h1, 0, 0, 0);
        chk("R7 no read response while busy", int'(rd_valid), 0);
        wait_idle();
        rd_chk(4'h3, 0, 3, "R3 storage write", 7);

        // Undefined opcodes (R10)
        cmd(4'hC, 0, 0, 33);
        chk("R10 wiper unchanged", int'(wiper_pos[5:0]), 40);
        chk("R10 no read response", int'(rd_valid), 0);
        chk("R10 no busy", int'(busy), 0);
        cmd(4'h0, 1, 0, 33);
        chk("R10 op0 wiper unchanged", int'(wiper_pos[11:6]), 19);

        // Comparator gating (R11)
        cmp_raw = 2'b01;
        cmd(4'h2, 2, 0, 57);
        rd_chk(4'h1, 2, 0, "R11 spare bits read back", 57);
        chk("R11 follow raw", int'(cmp_out[0]), 1);
        chk("R11 enable", int'(cmp_oe[0]), 1);
        cmd(4'h2, 2, 0, 3);
        cmp_raw = 2'b00;
        @(posedge clk); #1;
        chk("R11 frozen value held", int'(cmp_out[0]), 1);
        cmd(4'h2, 2, 0, 1);
        chk("R11 unfrozen follows raw", int'(cmp_out[0]), 0);
        cmp_raw = 2'b01;
        #1 chk("R11 follows raw same cycle", int'(cmp_out[0]), 1);
        cmd(4'h2, 2, 0, 5);
        chk("R11 shutdown forces low", int'(cmp_out[0]), 0);
        cmd(4'h2, 2, 0, 0);
        chk("R11 output disabled", int'(cmp_oe[0]), 0);

        // Second reset: recall (R8)
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R8 recall ch0", int'(wiper_pos[5:0]), 3);
        chk("R8 recall ch1", int'(wiper_pos[11:6]), 19);
        chk("R8 busy low", int'(busy), 0);
        chk("R8 rd_valid low", int'(rd_valid), 0);
        rd_chk(4'h1, 3, 0, "R8 recall control u3", 51);
        rd_chk(4'h3, 0, 3, "R8 storage kept through reset", 7);

        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule